// File: doc/BRIEF.md
# Memory On-Die Termination Sequencer

This block chooses, on every clock cycle, which termination a memory device presents on its data pins. When no command is in progress it looks at the external termination pin and the park and nominal enables. The pin low selects park termination and the pin high selects nominal termination. Either one becomes off (high-Z) when its enable is clear.

Two timed windows, set off by commands, override that choice. A WRITE command opens a write-termination window. A READ command opens a window in which termination is forced off. Each window has a start delay and a length, and both are worked out from the latency, burst-length, preamble and CRC inputs in the cycle the command is accepted.

The output comes out twice. `term_o` carries it as a code and `term_oh_o` carries it one-hot. A separate flag powers down the termination receiver whenever nominal termination is disabled.

Top module: `odt_seq`

## Requirements
- R1: With park, nominal and write termination all disabled, `term_o` is 0 (off) in every cycle, whatever the pin and commands do.
- R2: Outside any active window, with `odt_pin_i` low, `term_o` is 1 (park) if `park_en_i` is set and 0 (off) otherwise.
- R3: Outside any active window, with `odt_pin_i` high, `term_o` is 2 (nominal) if `nom_en_i` is set and 0 (off) otherwise.
- R4: A WRITE command accepted on clock edge E opens a write window. The window starts max(WL−off, 0) cycles after E and lasts BL/2+WR_ADD cycles, where off is 2 with `pre2_i`=0 and 3 with `pre2_i`=1. While the window is open and `wr_en_i` is set, `term_o` is 3 (write), whatever the pin, park and nominal settings. With `wr_en_i` clear, the selection of R2 and R3 applies instead.
- R5: A READ command accepted on edge E forces `term_o` to 0 starting max(RL−2, 0) cycles after E when `pre2_i`=0, and max(RL−3, 0) cycles after E when `pre2_i`=1.
- R6: The read-off window lasts BL/2+2+`pre2_i`+`crc_en_i` cycles. The four lengths are BL/2+2, BL/2+3, BL/2+3 and BL/2+4.
- R7: While the read-off window is open, `term_o` is 0. This holds over the pin, the park and nominal settings, and any open write window.
- R8: `rx_pd_o` is 1 exactly when `nom_en_i` is 0.
- R9: A READ command accepted before the previous read window has ended restarts the read timing from the new command. The earlier window is discarded.
- R10: `rl_i`, `wl_i`, `bl_i`, `pre2_i` and `crc_en_i` are sampled on the command edge. Changing them afterwards does not alter the window already scheduled.
- R11: `term_oh_o` has exactly one bit set, bit `term_o` (bit0 off, bit1 park, bit2 nominal, bit3 write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| park_en_i | input | 1 | Park termination enabled |
| nom_en_i | input | 1 | Nominal termination enabled |
| wr_en_i | input | 1 | Write termination enabled |
| odt_pin_i | input | 1 | External termination control pin |
| rd_cmd_i | input | 1 | READ command strobe |
| wr_cmd_i | input | 1 | WRITE command strobe |
| rl_i | input | LAT_W | Read latency in cycles |
| wl_i | input | LAT_W | Write latency in cycles |
| bl_i | input | BL_W | Burst length in beats |
| pre2_i | input | 1 | 1: two-clock preamble, 0: one-clock preamble |
| crc_en_i | input | 1 | CRC enabled |
| term_o | output | 2 | Termination code: 0 off, 1 park, 2 nominal, 3 write |
| term_oh_o | output | 4 | One-hot form of term_o |
| rx_pd_o | output | 1 | Termination receiver power-down |

## Verification
The bench walks all four preamble and CRC combinations and checks every cycle from the command to past the end of the window. A design with the wrong offset or length is off by one cycle at the window's first or last edge.

It also tests a latency small enough that the start delay clamps to zero, which catches an unsigned counter that wraps around. Latency and burst length are scrambled right after each command, so a design that reads them live shifts the window.

A read issued inside a write window must win from its first off cycle. A second read issued before the first window starts must erase the first window completely. A design that keeps the old countdown shows off cycles at the stale position.

// File: rtl/odt_pkg.sv
package odt_pkg;
  typedef enum logic [1:0] {
    TERM_OFF  = 2'd0,
    TERM_PARK = 2'd1,
    TERM_NOM  = 2'd2,
    TERM_WR   = 2'd3
  } term_e;
  localparam int unsigned NUM_TERM = 4;
endpackage

// File: rtl/odt_win.sv
module odt_win #(
  parameter int unsigned DLY_W = 6,
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             act_o
);
  logic [DLY_W-1:0] dly_q;
  logic [LEN_W-1:0] len_q;

  // a new start always overrides a pending or running window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      len_q <= '0;
    end else if (start_i) begin
      dly_q <= dly_i;
      len_q <= len_i;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end else if (len_q != '0) begin
      len_q <= len_q - 1'b1;
    end
  end

  assign act_o = (dly_q == '0) && (len_q != '0);

  // R6: an open window shrinks by exactly one cycle per clock
  a_r6_len_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o && !start_i |=> len_q == $past(len_q) - 1'b1);
  // R9: an idle window stays idle unless restarted
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && len_q == '0 |=> !act_o);
endmodule

// File: rtl/odt_sel.sv
module odt_sel
  import odt_pkg::*;
(
  input  logic  park_en_i,
  input  logic  nom_en_i,
  input  logic  wr_en_i,
  input  logic  odt_pin_i,
  input  logic  rd_act_i,
  input  logic  wr_act_i,
  output term_e term_o
);
  term_e stby;

  always_comb begin
    if (odt_pin_i) stby = nom_en_i  ? TERM_NOM  : TERM_OFF;
    else           stby = park_en_i ? TERM_PARK : TERM_OFF;
  end

  // read-off beats write, write beats standby
  always_comb begin
    if (rd_act_i)                 term_o = TERM_OFF;
    else if (wr_act_i && wr_en_i) term_o = TERM_WR;
    else                          term_o = stby;
  end
endmodule

// File: rtl/odt_seq.sv
module odt_seq
  import odt_pkg::*;
#(
  parameter int unsigned LAT_W  = 6,
  parameter int unsigned BL_W   = 5,
  parameter int unsigned WR_ADD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             park_en_i,
  input  logic             nom_en_i,
  input  logic             wr_en_i,
  input  logic             odt_pin_i,
  input  logic             rd_cmd_i,
  input  logic             wr_cmd_i,
  input  logic [LAT_W-1:0] rl_i,
  input  logic [LAT_W-1:0] wl_i,
  input  logic [BL_W-1:0]  bl_i,
  input  logic             pre2_i,
  input  logic             crc_en_i,
  output logic [1:0]       term_o,
  output logic [NUM_TERM-1:0] term_oh_o,
  output logic             rx_pd_o
);
  logic [LAT_W-1:0] pre_off, rd_dly, wr_dly;
  logic [BL_W-1:0]  half_bl, rd_len, wr_len;
  logic             rd_act, wr_act;
  term_e            term;

  assign pre_off = pre2_i ? LAT_W'(3) : LAT_W'(2);
  assign half_bl = bl_i >> 1;
  assign rd_dly  = (rl_i > pre_off) ? rl_i - pre_off : '0;
  assign wr_dly  = (wl_i > pre_off) ? wl_i - pre_off : '0;
  assign rd_len  = half_bl + BL_W'(2) + BL_W'(pre2_i) + BL_W'(crc_en_i);
  assign wr_len  = half_bl + BL_W'(WR_ADD);

  odt_win #(.DLY_W(LAT_W), .LEN_W(BL_W)) u_rd_win (
    .clk_i, .rst_ni, .start_i(rd_cmd_i), .dly_i(rd_dly), .len_i(rd_len), .act_o(rd_act)
  );

  odt_win #(.DLY_W(LAT_W), .LEN_W(BL_W)) u_wr_win (
    .clk_i, .rst_ni, .start_i(wr_cmd_i), .dly_i(wr_dly), .len_i(wr_len), .act_o(wr_act)
  );

  odt_sel u_sel (
    .park_en_i, .nom_en_i, .wr_en_i, .odt_pin_i,
    .rd_act_i(rd_act), .wr_act_i(wr_act), .term_o(term)
  );

  assign term_o = term;

  for (genvar g = 0; g < NUM_TERM; g++) begin : g_oh
    assign term_oh_o[g] = (term == term_e'(g));
  end

  assign rx_pd_o = !nom_en_i;

  // R1: nothing enabled means always off
  a_r1_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !park_en_i && !nom_en_i && !wr_en_i |-> term_o == TERM_OFF);
  // R2: park only with pin low and park enabled
  a_r2_park_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o == TERM_PARK |-> !odt_pin_i && park_en_i && !rd_act);
  // R3: nominal only with pin high and nominal enabled
  a_r3_nom_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o == TERM_NOM |-> odt_pin_i && nom_en_i && !rd_act);
  // R7: read window forces off
  a_r7_rd_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act |-> term_oh_o == 4'b0001);
  // R11: one-hot output
  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(term_oh_o) == 1);
endmodule

// File: tb/sim_odt_seq.sv
`timescale 1ns/1ps
module sim_odt_seq;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       park_en = 0, nom_en = 0, wr_en = 0, pin = 0;
  logic       rd_cmd = 0, wr_cmd = 0, pre2 = 0, crc = 0;
  logic [5:0] rl = 6'd10, wl = 6'd10;
  logic [4:0] bl = 5'd8;
  logic [1:0] term;
  logic [3:0] term_oh;
  logic       rx_pd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  odt_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .park_en_i(park_en), .nom_en_i(nom_en),
    .wr_en_i(wr_en), .odt_pin_i(pin), .rd_cmd_i(rd_cmd), .wr_cmd_i(wr_cmd),
    .rl_i(rl), .wl_i(wl), .bl_i(bl), .pre2_i(pre2), .crc_en_i(crc),
    .term_o(term), .term_oh_o(term_oh), .rx_pd_o(rx_pd)
  );

  // {park, nom, wr, pin, expected term, expected rx_pd}
  localparam logic [6:0] VEC [16] = '{
    {4'b0000, 2'd0, 1'b1}, {4'b0001, 2'd0, 1'b1},
    {4'b0010, 2'd0, 1'b1}, {4'b0011, 2'd0, 1'b1},
    {4'b0100, 2'd0, 1'b0}, {4'b0101, 2'd2, 1'b0},
    {4'b0110, 2'd0, 1'b0}, {4'b0111, 2'd2, 1'b0},
    {4'b1000, 2'd1, 1'b1}, {4'b1001, 2'd0, 1'b1},
    {4'b1010, 2'd1, 1'b1}, {4'b1011, 2'd0, 1'b1},
    {4'b1100, 2'd1, 1'b0}, {4'b1101, 2'd2, 1'b0},
    {4'b1110, 2'd1, 1'b0}, {4'b1111, 2'd2, 1'b0}
  };

  task automatic chk(input logic [3:0] got, input logic [3:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_term(input logic [1:0] exp, input string tag);
    chk({2'b0, term}, {2'b0, exp}, tag);
    chk(term_oh, 4'b1 << exp, {tag, " R11"});
  endtask

  // issue one command, scramble sampled inputs, then check every cycle
  task automatic cmd_scan(input bit is_rd, input int lat, input int bl_v, input bit p2,
                          input bit c, input int d, input int l,
                          input logic [1:0] win, input logic [1:0] stby, input string tag);
    @(negedge clk);
    rl = 6'(lat); wl = 6'(lat); bl = 5'(bl_v); pre2 = p2; crc = c;
    rd_cmd = is_rd; wr_cmd = !is_rd;
    @(posedge clk);
    @(negedge clk);
    rd_cmd = 0; wr_cmd = 0;
    rl = 6'd3; wl = 6'd3; bl = 5'd2; pre2 = !p2; crc = !c; // R10
    for (int j = 0; j < d + l + 3; j++) begin
      #1 chk_term((j >= d && j < d + l) ? win : stby, $sformatf("%s j=%0d", tag, j));
      @(negedge clk);
    end
    pre2 = 0; crc = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk_term(2'd0, "R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk_term(2'd0, "R1 after reset");
    chk({3'b0, rx_pd}, 4'd1, "R8 after reset");

    // standby table: R1 R2 R3 R8
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {park_en, nom_en, wr_en, pin} = VEC[i][6:3];
      #1;
      chk_term(VEC[i][2:1], $sformatf("R2/R3 vec %0d", i));
      chk({3'b0, rx_pd}, {3'b0, VEC[i][0]}, $sformatf("R8 vec %0d", i));
    end

    // read windows, pin low park on: R5 R6 R7 R10
    park_en = 1; nom_en = 1; wr_en = 1; pin = 0;
    cmd_scan(1, 10, 8, 0, 0, 8, 6, 2'd0, 2'd1, "R5/R6 p1c0");
    cmd_scan(1, 10, 8, 0, 1, 8, 7, 2'd0, 2'd1, "R5/R6 p1c1");
    pin = 1;
    cmd_scan(1, 10, 8, 1, 0, 7, 7, 2'd0, 2'd2, "R5/R6/R7 p2c0");
    cmd_scan(1, 10, 8, 1, 1, 7, 8, 2'd0, 2'd2, "R5/R6/R7 p2c1");
    cmd_scan(1, 2, 4, 0, 0, 0, 4, 2'd0, 2'd2, "R5 clamp zero");
    cmd_scan(1, 12, 16, 1, 1, 9, 12, 2'd0, 2'd2, "R6 bl16");

    // write windows: R4
    cmd_scan(0, 9, 8, 0, 0, 7, 6, 2'd3, 2'd2, "R4 wr pin high");
    pin = 0;
    cmd_scan(0, 9, 8, 1, 0, 6, 6, 2'd3, 2'd1, "R4 wr pin low p2");
    wr_en = 0;
    cmd_scan(0, 9, 8, 0, 0, 7, 6, 2'd1, 2'd1, "R4 wr disabled");

    // R1 with commands and nothing enabled
    park_en = 0; nom_en = 0; pin = 1;
    cmd_scan(0, 8, 8, 0, 0, 6, 6, 2'd0, 2'd0, "R1 write");
    cmd_scan(1, 8, 8, 0, 0, 6, 6, 2'd0, 2'd0, "R1 read");

    // R7 read over write: write active j10..15, read active j12..17
    park_en = 1; nom_en = 1; wr_en = 1; pin = 0;
    @(negedge clk);
    wl = 6'd12; rl = 6'd12; bl = 5'd8; pre2 = 0; crc = 0; wr_cmd = 1;
    @(posedge clk);
    @(negedge clk);
    wr_cmd = 0;
    for (int j = 0; j < 22; j++) begin
      #1 chk_term((j >= 12 && j < 18) ? 2'd0 : (j >= 10 && j < 12) ? 2'd3 : 2'd1,
                  $sformatf("R7 overlap j=%0d", j));
      rd_cmd = (j == 1);
      @(negedge clk);
    end

    // R9 restart: first read D=18, second read at edge 3 gives j11..16
    pin = 1;
    @(negedge clk);
    rl = 6'd20; bl = 5'd8; rd_cmd = 1;
    @(posedge clk);
    @(negedge clk);
    rd_cmd = 0;
    for (int j = 0; j < 27; j++) begin
      #1 chk_term((j >= 11 && j < 17) ? 2'd0 : 2'd2, $sformatf("R9 restart j=%0d", j));
      rd_cmd = (j == 2);
      rl = 6'd10;
      @(negedge clk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule